// File: doc/BRIEF.md
# Byte-Lane Parity Guard for Single-Port RAM

This block sits between a requester and a single-port synchronous RAM and adds one parity bit to every 8-bit byte lane of each stored word. Each write computes the lane parity bits and stores them next to the data, whether or not read checking is on. Each read returns the stored word one cycle later. When checking is on, the block recomputes the lane parity from the returned data and compares it with the stored bits. A mismatch raises an error flag in the same cycle as the read response.

The parity sense (even or odd) is a runtime input that applies to both generation and checking. The check-enable bit is loaded from a pin while reset is held and can be rewritten later through a one-cycle configuration strobe. The block never corrects data. A read that is flagged returns exactly the bits held in the array.

Top module: `mem_parity_wrap`

## Requirements
- R1: Every accepted write stores one parity bit for each strobed lane, whether checking is enabled or disabled. Lane i is `req_wdata[8i+7:8i]` and is guarded by `req_wstrb[i]`. With even sense (`par_odd`=0) the stored bit is the XOR of the lane's eight bits. With odd sense (`par_odd`=1) it is the inverse of that XOR.
- R2: With checking enabled, a read whose stored parity differs from the parity recomputed from the returned data, in any lane, drives `rsp_err` high in its `rsp_valid` cycle.
- R3: `par_odd` selects the sense for both generation and checking. It is sampled in the cycle the request is accepted, and a change during the response cycle has no effect. A word written under one sense and read under the other mismatches in every lane.
- R4: The check-enable bit takes the value of `chk_en_rst` while `rst_n` is low. A clock edge with `cfg_we` high loads `cfg_chk_en` into it. The new value applies to reads accepted from the next cycle on.
- R5: `rsp_rdata` carries the stored word unchanged, including when `rsp_err` is high.
- R6: A write updates the data and the parity only of lanes whose strobe bit is 1. A write with `req_wstrb`=0 changes nothing.
- R7: A read accepted at a clock edge produces `rsp_valid` high for exactly the following cycle. Writes produce no response. `rsp_err` is high only together with `rsp_valid`, and `rsp_valid` is low during reset.
- R8: While checking is disabled, `rsp_err` never asserts, even for words whose stored parity is wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en_rst | input | 1 | Check-enable value loaded during reset |
| cfg_we | input | 1 | Load strobe for the check-enable bit |
| cfg_chk_en | input | 1 | New check-enable value |
| par_odd | input | 1 | 1 = odd parity sense, 0 = even |
| req_valid | input | 1 | Request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Per-lane write strobes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Parity error for this read |

## Verification
The bench corrupts lanes only through the normal interface. It rewrites a single lane under the opposite parity sense, which leaves exactly that lane's stored bit wrong. It then reads the word under both senses, with checking on and off. A design that stored parity only while checking was on would flag words written during a disabled period after checking is turned back on. A design that merged strobes wrongly would return corrupted neighbouring lanes or flag partial writes, and the sweep over all sixteen strobe masks catches both. A design that sampled the sense or the enable at response time instead of at accept time, or that ignored the reset pin value, would flip the flag in the dedicated sense-toggle and reset-pin tests. Back-to-back reads of a corrupted word followed by a clean word catch an error flag that is held too long.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_sense_e;

  // Fold a lane's XOR reduction into a stored parity bit for the chosen sense.
  function automatic logic sense_fold(input logic lane_xor, input par_sense_e sense);
    return lane_xor ^ (sense == PAR_ODD);
  endfunction

  // Per-lane merge: keep old bits where the strobe is clear.
  function automatic logic lane_pick(input logic strobe, input logic new_bit, input logic old_bit);
    return strobe ? new_bit : old_bit;
  endfunction

endpackage

// File: rtl/mpw_parity_gen.sv
module mpw_parity_gen
  import mpw_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  par_sense_e              sense,
  output logic [LANES-1:0]        par
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = sense_fold(^data[g*LANE_W +: LANE_W], sense);
  end

endmodule

// File: rtl/mpw_ram.sv
module mpw_ram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wstrb,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wpar,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rpar
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [LANES-1:0]  par_mem  [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (en && we && wstrb[g]) begin
        data_mem[addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
        par_mem[addr][g]                   <= wpar[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) begin
      rdata <= data_mem[addr];
      rpar  <= par_mem[addr];
    end
  end

endmodule

// File: rtl/mpw_cfg.sv
module mpw_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_val,
  input  logic we,
  input  logic wval,
  output logic chk_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  chk_en <= rst_val;
    else if (we) chk_en <= wval;
  end

  // R4
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> chk_en == $past(wval));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(chk_en));

endmodule

// File: rtl/mem_parity_wrap.sv
module mem_parity_wrap
  import mpw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chk_en_rst,
  input  logic                    cfg_we,
  input  logic                    cfg_chk_en,
  input  logic                    par_odd,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_wstrb,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic                    rsp_err
);

  localparam int DATA_W = LANES * LANE_W;

  // Named internal events
  logic              rd_issue;
  logic              chk_en;
  par_sense_e        sense_now;
  logic [LANES-1:0]  wr_par;
  logic [DATA_W-1:0] ram_rdata;
  logic [LANES-1:0]  ram_rpar;
  logic [LANES-1:0]  calc_par;
  logic [LANES-1:0]  lane_mismatch;

  // Response-side pipeline state
  logic       rvalid_q;
  logic       rchk_q;
  par_sense_e rsense_q;

  assign rd_issue  = req_valid && !req_we;
  assign sense_now = par_sense_e'(par_odd);

  mpw_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (chk_en_rst),
    .we      (cfg_we),
    .wval    (cfg_chk_en),
    .chk_en  (chk_en)
  );

  mpw_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wgen (
    .data  (req_wdata),
    .sense (sense_now),
    .par   (wr_par)
  );

  mpw_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk   (clk),
    .en    (req_valid),
    .we    (req_we),
    .addr  (req_addr),
    .wstrb (req_wstrb),
    .wdata (req_wdata),
    .wpar  (wr_par),
    .rdata (ram_rdata),
    .rpar  (ram_rpar)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rchk_q   <= 1'b0;
      rsense_q <= PAR_EVEN;
    end else begin
      rvalid_q <= rd_issue;
      if (rd_issue) begin
        rchk_q   <= chk_en;
        rsense_q <= sense_now;
      end
    end
  end

  mpw_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_rgen (
    .data  (ram_rdata),
    .sense (rsense_q),
    .par   (calc_par)
  );

  assign lane_mismatch = calc_par ^ ram_rpar;

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = ram_rdata;
  assign rsp_err   = rvalid_q && rchk_q && (|lane_mismatch);

  // R7
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> rsp_valid);

  // R7
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_issue |=> !rsp_valid);

  // R7
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && !chk_en) |=> !rsp_err);

endmodule

// File: tb/mem_parity_wrap_test.sv
module mem_parity_wrap_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_en_rst;
  logic        cfg_we;
  logic        cfg_chk_en;
  logic        par_odd;
  logic        req_valid;
  logic        req_we;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_wstrb;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int nchk = 0;
  int nfail = 0;

  // Bench model: data and the sense each lane was last written under.
  logic [31:0] sh_data  [16];
  logic [3:0]  sh_sense [16];
  bit          en_model;

  always #2 clk = ~clk;

  mem_parity_wrap uut (
    .clk(clk), .rst_n(rst_n), .chk_en_rst(chk_en_rst), .cfg_we(cfg_we),
    .cfg_chk_en(cfg_chk_en), .par_odd(par_odd), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mism(input int a, input bit s);
    for (int l = 0; l < 4; l++) if (sh_sense[a][l] != s) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] pat(input int a, input int k);
    return (32'h0101_0101 * (a + 3)) ^ (32'h9E37_79B9 * (k + 1));
  endfunction

  task automatic do_reset(input bit v);
    @(negedge clk);
    rst_n = 1'b0; chk_en_rst = v;
    @(negedge clk); @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R7 reset outputs", {30'd0, rsp_valid, rsp_err}, 32'd0);
    rst_n = 1'b1;
    en_model = v;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] st, input bit s);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 4'(a); req_wdata = d; req_wstrb = st; par_odd = s;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    #1;
    check(rsp_valid == 1'b0, "R7 write gives no response", {31'd0, rsp_valid}, 32'd0);
    for (int l = 0; l < 4; l++) if (st[l]) begin
      sh_data[a][l*8 +: 8] = d[l*8 +: 8];
      sh_sense[a][l] = s;
    end
  endtask

  task automatic rd(input int a, input bit s, input bit flip, input string req);
    logic [31:0] ed;
    bit ee;
    ed = sh_data[a];
    ee = en_model && mism(a, s);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 4'(a); par_odd = s;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) par_odd = ~s;
    #1;
    check(rsp_valid == 1'b1, {req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check(rsp_rdata == ed, {req, " data (R5)"}, rsp_rdata, ed);
    check(rsp_err == ee, {req, " err"}, {31'd0, rsp_err}, {31'd0, ee});
  endtask

  task automatic cfg(input bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chk_en = v;
    @(negedge clk);
    cfg_we = 1'b0;
    en_model = v;
  endtask

  initial begin
    #700000;
    nfail++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chk_en_rst = 1'b1; cfg_we = 1'b0; cfg_chk_en = 1'b0; par_odd = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_wstrb = '0;
    en_model = 1'b1;
    do_reset(1'b1);

    // R1: fill every word under even sense, read back clean.
    for (int a = 0; a < 16; a++) wr(a, pat(a, 0), 4'hF, 1'b0);
    for (int a = 0; a < 16; a++) rd(a, 1'b0, 1'b0, "R1 even fill");

    // R3: odd sense round trip, then cross-sense reads mismatch everywhere.
    for (int a = 0; a < 16; a++) wr(a, pat(a, 1), 4'hF, 1'b1);
    for (int a = 0; a < 16; a++) rd(a, 1'b1, 1'b0, "R3 odd fill");
    for (int a = 0; a < 16; a += 5) rd(a, 1'b0, 1'b0, "R3 cross sense");

    // R2: a single lane stored with the wrong bit, both senses as base.
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 4; l++) begin
        wr(l + 2, pat(l, s + 4), 4'hF, bit'(s));
        wr(l + 2, pat(l, s + 9), 4'(1 << l), ~bit'(s));
        rd(l + 2, bit'(s), 1'b0, "R2 lane corrupt");
        rd(l + 2, ~bit'(s), 1'b0, "R2 other lanes");
        wr(l + 2, pat(l, s + 9), 4'(1 << l), bit'(s));
        rd(l + 2, bit'(s), 1'b0, "R2 repaired");
      end

    // R6: every strobe mask, including zero.
    for (int m = 0; m < 16; m++) begin
      wr(8, pat(m, 20), 4'hF, 1'b0);
      wr(8, pat(m, 21), 4'(m), 1'b0);
      rd(8, 1'b0, 1'b0, "R6 strobe merge");
    end

    // R3: sense change during the response cycle has no effect.
    wr(9, pat(9, 30), 4'hF, 1'b1);
    rd(9, 1'b1, 1'b1, "R3 sense sampled at accept");
    rd(9, 1'b0, 1'b1, "R3 sense sampled at accept x");

    // R8 and R1: disable, corrupted reads stay quiet, writes still store parity.
    wr(10, pat(10, 31), 4'hF, 1'b0);
    wr(10, pat(10, 32), 4'b0100, 1'b1);
    cfg(1'b0);
    rd(10, 1'b0, 1'b0, "R8 disabled corrupt");
    rd(10, 1'b1, 1'b0, "R8 disabled cross");
    wr(12, pat(12, 33), 4'hF, 1'b1);
    cfg(1'b1);
    rd(12, 1'b1, 1'b0, "R1 written while disabled");
    rd(10, 1'b0, 1'b0, "R4 re-enabled");

    // R7: back-to-back reads, corrupted then clean.
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 4'd10; par_odd = 1'b0;
    @(negedge clk);
    req_addr = 4'd12; par_odd = 1'b1;
    #1;
    check(rsp_valid && rsp_err && rsp_rdata == sh_data[10], "R7 b2b first", {31'd0, rsp_err}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(rsp_valid && !rsp_err && rsp_rdata == sh_data[12], "R7 b2b second", {31'd0, rsp_err}, 32'd0);
    @(negedge clk);
    #1;
    check(rsp_valid == 1'b0, "R7 single cycle", {31'd0, rsp_valid}, 32'd0);

    // R4: reset pin value sets the enable; memory persists.
    do_reset(1'b0);
    rd(10, 1'b0, 1'b0, "R4 reset disabled");
    do_reset(1'b1);
    rd(10, 1'b0, 1'b0, "R4 reset enabled");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule